// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers per-channel event pulses from a multi-channel DMA engine and turns them into one interrupt line plus a set of registers that software reads and writes. Three event classes are kept for every channel: transfer done, error class A and error class B. Each class has a sticky raw latch, an enable mask and a masked view (raw AND mask). A summary register ORs the three masked views per channel, so a handler reads one word to see which channels need attention. It then reads the class views and acknowledges events by writing ones to the raw latches.

The block also shows a live channel-active vector that software must see at zero before powering the engine down. It holds a channel-priority word that is passed to the engine, where zero means all channels have equal standing. The register port is a simple one: single-cycle writes, and reads that return data one cycle after the request.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every raw latch, every mask, the priority word and the interrupt output are zero, and every mapped register reads zero.
- R2: A one on an event input bit in a cycle sets the matching raw bit at that clock edge; the bit stays set until software clears it. Raw offsets: done 0x600, error A 0x608, error B 0x610; bit i is channel i.
- R3: Writing a raw register clears each bit written as one and leaves each bit written as zero unchanged.
- R4: When an event and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Masks are enable-high and read back as written (done 0x018, error A 0x020, error B 0x024). The masked views (done 0x004, error A 0x00C, error B 0x010) read raw AND mask. A cleared mask hides an event but leaves its raw bit set.
- R6: The summary register (0x000) has bit i set exactly when channel i has any masked event pending in any class.
- R7: The interrupt output is a register. It is high in the cycle after a cycle with any summary bit set, and low in the cycle after a cycle with none.
- R8: The active-channel register (0x690) reads the channel-active input vector as sampled on the read cycle.
- R9: The priority register (0x688) holds all bits written to it, reads them back and drives them on the priority output; zero means equal priority.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets, and to the read-only offsets 0x000, 0x004, 0x00C, 0x010 and 0x690, change no state.
- R11: Read data appears in the cycle after the read request and is zero in any cycle after a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | NUM_CH | Per-channel transfer-done pulses |
| ev_err_a | input | NUM_CH | Per-channel error class A pulses |
| ev_err_b | input | NUM_CH | Per-channel error class B pulses |
| chan_active | input | NUM_CH | Live per-channel running flags from the engine |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| prio_level | output | DATA_W | Stored channel-priority word |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle, and that the event inputs are clean one-cycle-per-event levels sampled at the clock. They do not assume any relation between events and register writes, so a same-cycle event and clear is legal and is checked. The bench drives every input on the falling edge and never raises both strobes together. It raises events both alone and together with a clearing write, which keeps the stimulus inside these assumptions while still reaching the collision case.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    localparam int ADDR_W = 12;
    localparam int NUM_CLS = 3;

    localparam logic [ADDR_W-1:0] OFS_SUMMARY   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT_DONE = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT_ERRA = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_STAT_ERRB = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASK_DONE = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MASK_ERRA = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_MASK_ERRB = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_RAW_DONE  = 12'h600;
    localparam logic [ADDR_W-1:0] OFS_RAW_ERRA  = 12'h608;
    localparam logic [ADDR_W-1:0] OFS_RAW_ERRB  = 12'h610;
    localparam logic [ADDR_W-1:0] OFS_PRIO      = 12'h688;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE    = 12'h690;

    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_ERRA = 2'd1,
        CLS_ERRB = 2'd2
    } ev_cls_e;
endpackage

// File: rtl/dirq_event_bank.sv
module dirq_event_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] stat
);
    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic [NUM_CH-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.raw = st_q.raw & ~wdata;
        end
        st_d.raw = st_d.raw | evt;
        if (mask_we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign stat   = st_q.raw & st_q.mask;

    // R2 R4
    ev_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

    // R3
    clr_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(wdata & ~evt)) == '0));

    // R3
    clr_keeps_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(~wdata & raw_q)) == $past(~wdata & raw_q)));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/dirq_regfile.sv
module dirq_regfile
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic                            reg_rd,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0]  raw,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0]  mask,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0]  stat,
    input  logic [NUM_CH-1:0]               summary,
    input  logic [NUM_CH-1:0]               active,
    output logic [NUM_CLS-1:0]              clr_we,
    output logic [NUM_CLS-1:0]              mask_we,
    output logic [DATA_W-1:0]               prio_q,
    output logic [DATA_W-1:0]               rdata_q
);
    typedef struct packed {
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] rdata;
    } rf_t;

    rf_t st_d, st_q;
    logic mapped;

    always_comb begin
        clr_we  = '0;
        mask_we = '0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_RAW_DONE:  clr_we[CLS_DONE]  = 1'b1;
                OFS_RAW_ERRA:  clr_we[CLS_ERRA]  = 1'b1;
                OFS_RAW_ERRB:  clr_we[CLS_ERRB]  = 1'b1;
                OFS_MASK_DONE: mask_we[CLS_DONE] = 1'b1;
                OFS_MASK_ERRA: mask_we[CLS_ERRA] = 1'b1;
                OFS_MASK_ERRB: mask_we[CLS_ERRB] = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        mapped     = 1'b1;
        if (reg_wr && reg_addr == OFS_PRIO) begin
            st_d.prio = reg_wdata;
        end
        case (reg_addr)
            OFS_SUMMARY:   st_d.rdata = DATA_W'(summary);
            OFS_STAT_DONE: st_d.rdata = DATA_W'(stat[CLS_DONE]);
            OFS_STAT_ERRA: st_d.rdata = DATA_W'(stat[CLS_ERRA]);
            OFS_STAT_ERRB: st_d.rdata = DATA_W'(stat[CLS_ERRB]);
            OFS_MASK_DONE: st_d.rdata = DATA_W'(mask[CLS_DONE]);
            OFS_MASK_ERRA: st_d.rdata = DATA_W'(mask[CLS_ERRA]);
            OFS_MASK_ERRB: st_d.rdata = DATA_W'(mask[CLS_ERRB]);
            OFS_RAW_DONE:  st_d.rdata = DATA_W'(raw[CLS_DONE]);
            OFS_RAW_ERRA:  st_d.rdata = DATA_W'(raw[CLS_ERRA]);
            OFS_RAW_ERRB:  st_d.rdata = DATA_W'(raw[CLS_ERRB]);
            OFS_PRIO:      st_d.rdata = st_q.prio;
            OFS_ACTIVE:    st_d.rdata = DATA_W'(active);
            default:       mapped     = 1'b0;
        endcase
        if (!reg_rd) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prio_q  = st_q.prio;
    assign rdata_q = st_q.rdata;

    // R10
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> (rdata_q == '0));

    // R11
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (rdata_q == '0));

    // R9
    prio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_PRIO) |=> (prio_q == $past(reg_wdata)));

    // R9
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFS_PRIO) |=> $stable(prio_q));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_err_a,
    input  logic [NUM_CH-1:0] ev_err_b,
    input  logic [NUM_CH-1:0] chan_active,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] prio_level,
    output logic              irq
);
    logic [NUM_CLS-1:0][NUM_CH-1:0] evt_v, raw_v, mask_v, stat_v;
    logic [NUM_CLS-1:0]             clr_we, mask_we;
    logic [NUM_CH-1:0]              summary;
    logic                           irq_d, irq_q;

    assign evt_v[CLS_DONE] = ev_done;
    assign evt_v[CLS_ERRA] = ev_err_a;
    assign evt_v[CLS_ERRB] = ev_err_b;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
        dirq_event_bank #(.NUM_CH(NUM_CH)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_v[c]),
            .clr_we  (clr_we[c]),
            .mask_we (mask_we[c]),
            .wdata   (reg_wdata[NUM_CH-1:0]),
            .raw_q   (raw_v[c]),
            .mask_q  (mask_v[c]),
            .stat    (stat_v[c])
        );
    end

    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            summary = summary | stat_v[c];
        end
        irq_d = |summary;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    dirq_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw_v),
        .mask      (mask_v),
        .stat      (stat_v),
        .summary   (summary),
        .active    (chan_active),
        .clr_we    (clr_we),
        .mask_we   (mask_we),
        .prio_q    (prio_level),
        .rdata_q   (reg_rdata)
    );

    assign irq = irq_q;

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_v != '0) |=> irq);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_v == '0) |=> !irq);

    // R6
    summary_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_v[CLS_DONE] & mask_v[CLS_DONE]) & ~summary) == '0);
endmodule

// File: tb/dma_irq_agg_tb_top.sv
module dma_irq_agg_tb_top;
    localparam int N = 16;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] ev_done = '0, ev_err_a = '0, ev_err_b = '0, chan_active = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata, prio_level;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [11:0] RAW_OFS [3]  = '{12'h600, 12'h608, 12'h610};
    localparam logic [11:0] MASK_OFS [3] = '{12'h018, 12'h020, 12'h024};
    localparam logic [11:0] STAT_OFS [3] = '{12'h004, 12'h00C, 12'h010};

    always #4 clk = ~clk;

    dma_irq_agg #(.NUM_CH(N), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_err_a(ev_err_a),
        .ev_err_b(ev_err_b), .chan_active(chan_active), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .prio_level(prio_level), .irq(irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_ev(input int cls, input logic [N-1:0] v);
        if (cls == 0) ev_done = v;
        else if (cls == 1) ev_err_a = v;
        else ev_err_b = v;
    endtask

    task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [W-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int cls, input logic [N-1:0] v);
        set_ev(cls, v);
        @(posedge clk); @(negedge clk);
        set_ev(cls, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        logic [W-1:0] exp_raw [3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", W'(irq), 0);
        chk("R1 prio", prio_level, 0);
        for (int c = 0; c < 3; c++) begin
            rd(RAW_OFS[c], r);  chk("R1 raw", r, 0);
            rd(MASK_OFS[c], r); chk("R1 mask", r, 0);
            rd(STAT_OFS[c], r); chk("R1 stat", r, 0);
        end
        rd(12'h000, r); chk("R1 summary", r, 0);
        rd(12'h688, r); chk("R1 prio rd", r, 0);

        // R5 mask readback
        for (int c = 0; c < 3; c++) begin
            wr(MASK_OFS[c], 32'hFFFF_FFFF);
            rd(MASK_OFS[c], r); chk("R5 mask rd", r, 32'h0000_FFFF);
        end

        // Sweep every class and channel
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < N; k++) begin
                logic [W-1:0] one;
                one = W'(1) << k;
                pulse(c, N'(one));
                rd(RAW_OFS[c], r);  chk("R2 raw set", r, one);
                chk("R7 irq high", W'(irq), 1);
                rd(STAT_OFS[c], r); chk("R5 stat", r, one);
                rd(12'h000, r);     chk("R6 summary", r, one);
                wr(MASK_OFS[c], 32'h0);
                rd(STAT_OFS[c], r); chk("R5 masked off", r, 0);
                rd(12'h000, r);     chk("R6 summary off", r, 0);
                chk("R7 irq low", W'(irq), 0);
                rd(RAW_OFS[c], r);  chk("R5 raw kept", r, one);
                wr(MASK_OFS[c], 32'h0000_FFFF);
                wr(RAW_OFS[c], one);
                rd(RAW_OFS[c], r);  chk("R3 cleared", r, 0);
            end
        end

        // R3 partial clear
        pulse(0, 16'hA5A5);
        wr(12'h600, 32'h0000_00F0);
        rd(12'h600, r); chk("R3 partial", r, 32'h0000_A505);
        wr(12'h600, 32'h0000_FFFF);
        rd(12'h600, r); chk("R3 all", r, 0);

        // R4 event beats same-cycle clear
        pulse(1, 16'h0020);
        ev_err_a = 16'h0008;
        wr(12'h608, 32'h0000_0028);
        ev_err_a = '0;
        rd(12'h608, r); chk("R4 collide", r, 32'h0000_0008);

        // R6 summary merges classes
        pulse(0, 16'h0101);
        pulse(2, 16'h0300);
        rd(12'h000, r); chk("R6 merge", r, 32'h0000_0309);
        exp_raw[0] = 32'h0101; exp_raw[1] = 32'h0008; exp_raw[2] = 32'h0300;

        // R8 active register
        for (int p = 0; p < 4; p++) begin
            logic [N-1:0] pat;
            pat = N'(16'h1 << (p * 5)) ^ N'(p * 16'h1111);
            chan_active = pat;
            rd(12'h690, r); chk("R8 active", r, W'(pat));
        end
        chan_active = '0;
        rd(12'h690, r); chk("R8 idle", r, 0);

        // R9 priority
        wr(12'h688, 32'h1234_5678);
        rd(12'h688, r); chk("R9 prio rd", r, 32'h1234_5678);
        chk("R9 prio out", prio_level, 32'h1234_5678);

        // R10 unmapped and read-only writes ignored
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h604, 32'hFFFF_FFFF);
        wr(12'h7FC, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h690, 32'hFFFF_FFFF);
        rd(12'h008, r); chk("R10 unmapped rd", r, 0);
        rd(12'h7FC, r); chk("R10 unmapped rd2", r, 0);
        for (int c = 0; c < 3; c++) begin
            rd(RAW_OFS[c], r);  chk("R10 raw intact", r, exp_raw[c]);
            rd(MASK_OFS[c], r); chk("R10 mask intact", r, 32'h0000_FFFF);
        end
        rd(12'h688, r); chk("R10 prio intact", r, 32'h1234_5678);

        // R11 read latency and idle zero
        reg_rd = 1'b1; reg_addr = 12'h688;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        chk("R11 data next", reg_rdata, 32'h1234_5678);
        @(posedge clk); @(negedge clk);
        chk("R11 idle zero", reg_rdata, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule